// File: doc/BRIEF.md
# Serializing Instruction Barrier Controller

This block sits between instruction fetch and the fetch buffer and decides whether each fetched instruction may go straight into the buffer or must first wait for the machine to go quiet. Every instruction arrives with a set of decoded flags and a sequence tag. Some instructions must see a fully drained pipeline before they run: an access to a control register, or anything marked "drain first". The controller holds such an instruction in a one-entry barrier slot and stops fetch. It releases the instruction only after the back end reports an empty reorder buffer and the fetch buffer is empty.

Instructions marked "drain after" (including store-conditionals) pass through at once and are marked as handled. The instruction that follows them is then treated as "drain first". A squash from the back end empties the barrier slot, cancels any pending "drain after" obligation and returns the controller to normal flow. Three counters record permanent serializing dispatches, temporary serializing dispatches and cycles spent waiting for the drain.

The state machine has four states. RUN is normal flow. HOLD waits for the drain with the barrier parked. RELEASE is the single cycle in which the parked instruction is delivered. BUBBLE is one dead cycle before RUN. The transitions are:
- PARK: RUN to HOLD, when a drain-first instruction is captured.
- DRAINED: HOLD to RELEASE, when the back end is empty and the buffer occupancy is zero.
- REPLAY: RELEASE to BUBBLE.
- RESUME: BUBBLE to RUN.
- FLUSH: any state to RUN, on a squash.

Top module: `serbar_ctrl`

## Requirements
- R1: After reset the state is RUN and all of the following read 0: `stall`, `bar_valid`, `replay`, `out_valid` and all three counters.
- R2: In RUN, when `in_valid` is high, the instruction carries no serializing flag and no drain-after obligation is pending, it is forwarded in the same cycle. The outputs are then `out_valid`=1, `out_tag`=`in_tag`, `out_sb`=0 and `out_handled`=`in_done`.
- R3: In RUN, an instruction with `in_done`=0 and either `in_creg`=1 or `in_sb`=1 is parked. In that same cycle `out_valid`=0 and `stall`=1. From the next cycle `bar_valid`=1, `bar_tag` holds its tag, and the state is HOLD.
- R4: An instruction with `in_done`=0, either `in_sa`=1 or `in_sc`=1, and no drain-first flag is forwarded with `out_handled`=1 and increments `cnt_perm`. The next accepted instruction is then treated as drain-first and parked even if its own flags are clear, and the obligation is cleared.
- R5: With `in_done`=1, the flags `in_sb`, `in_creg`, `in_sa` and `in_sc` cause no parking and no pending obligation. `out_sb` still reflects `in_sb`.
- R6: HOLD moves to RELEASE only at an edge where `be_empty`=1 and `fbuf_count`=0 together. With only one of the two, `stall` stays 1 and `replay` stays 0.
- R7: In RELEASE, the parked instruction is delivered with `replay`=1, `out_valid`=1, `out_tag`=`bar_tag` and `out_sb`=0. The next cycle is BUBBLE, with `stall`=1, `out_valid`=0 and `bar_valid`=0. RUN follows that.
- R8: A park with `in_temp`=0 increments `cnt_perm`, and its replay shows `out_handled`=1. A park with `in_temp`=1 increments `cnt_temp` instead, and its replay shows `out_handled`=0.
- R9: `squash_valid`=1 returns the controller to RUN at the next edge, clears `bar_valid` and cancels a pending drain-after obligation. A parked barrier's tag must exceed `squash_tag`.
- R10: `cnt_stall` increments once for every cycle spent in HOLD.
- R11: While `stall`=1 outside RELEASE, `in_valid` is ignored: `out_valid`=0 and the state does not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetched instruction is presented |
| in_tag | input | TAG_W | Sequence tag of the instruction |
| in_sb | input | 1 | Instruction must drain before it |
| in_sa | input | 1 | Instruction must drain after it |
| in_sc | input | 1 | Instruction is a store-conditional |
| in_creg | input | 1 | Instruction accesses a control register |
| in_temp | input | 1 | Drain-first mark is temporary |
| in_done | input | 1 | Serialization already handled |
| be_empty | input | 1 | Back-end reorder buffer is empty |
| fbuf_count | input | OCC_W | Fetch buffer occupancy |
| squash_valid | input | 1 | Squash request |
| squash_tag | input | TAG_W | Tag of the squash point |
| out_valid | output | 1 | Instruction is written to the fetch buffer |
| out_tag | output | TAG_W | Tag of the forwarded instruction |
| out_sb | output | 1 | Drain-first mark of the forwarded instruction |
| out_handled | output | 1 | Handled mark of the forwarded instruction |
| stall | output | 1 | Fetch must not present new instructions |
| bar_valid | output | 1 | Barrier slot is occupied |
| bar_tag | output | TAG_W | Tag of the parked barrier |
| replay | output | 1 | Parked barrier is released this cycle |
| cnt_perm | output | CNT_W | Permanent serializing dispatches |
| cnt_temp | output | CNT_W | Temporary serializing dispatches |
| cnt_stall | output | CNT_W | Cycles spent in HOLD |

## Verification
The forwarding outputs (`out_valid`, `out_tag`, `out_sb`, `out_handled`) and the park-cycle `stall` are combinational. The bench therefore samples them in the same cycle the stimulus is driven, 5 ns after the falling edge and before the next rising edge. `bar_valid`, `bar_tag` and the counters are registered, so their effects are checked one cycle after the stimulus. The drain condition sampled at an edge shows up as `replay` in the following cycle, and the BUBBLE cycle and the return to RUN are checked one and two cycles after that. Every check is placed on the exact cycle its register count predicts rather than waiting for a condition.

// File: rtl/serbar_pkg.sv
package serbar_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_BUBBLE  = 2'd3
    } bar_state_t;

    localparam int unsigned NUM_CNT = 3;
    localparam int unsigned CNT_PERM  = 0;
    localparam int unsigned CNT_TEMP  = 1;
    localparam int unsigned CNT_STALL = 2;
endpackage

// File: rtl/serbar_classify.sv
module serbar_classify (
    input  logic in_sb,
    input  logic in_sa,
    input  logic in_sc,
    input  logic in_creg,
    input  logic in_done,
    input  logic pend,
    output logic eff_sb,
    output logic park_req,
    output logic after_req
);
    always_comb begin
        eff_sb    = in_sb | pend;
        park_req  = (in_creg | eff_sb) & ~in_done;
        after_req = (in_sa | in_sc) & ~in_done & ~park_req;
    end
endmodule

// File: rtl/serbar_counter.sv
module serbar_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/serbar_fsm.sv
module serbar_fsm
    import serbar_pkg::*;
#(
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_temp,
    input  logic             in_done,
    input  logic             eff_sb,
    input  logic             park_req,
    input  logic             after_req,
    input  logic             drained,
    input  logic             squash_valid,
    output bar_state_t       state,
    output logic             pend,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_sb,
    output logic             out_handled,
    output logic             stall,
    output logic             bar_valid,
    output logic [TAG_W-1:0] bar_tag,
    output logic             replay,
    output logic             inc_perm,
    output logic             inc_temp,
    output logic             inc_stall
);
    bar_state_t state_nx;
    logic       bar_temp;
    logic       accept;
    logic       park;

    assign accept = (state == ST_RUN) && in_valid && !squash_valid;
    assign park   = accept && park_req;

    always_comb begin
        state_nx = state;
        if (squash_valid) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:     if (park) state_nx = ST_HOLD;
                ST_HOLD:    if (drained) state_nx = ST_RELEASE;
                ST_RELEASE: state_nx = ST_BUBBLE;
                ST_BUBBLE:  state_nx = ST_RUN;
                default:    state_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            pend      <= 1'b0;
            bar_valid <= 1'b0;
            bar_tag   <= '0;
            bar_temp  <= 1'b0;
        end else begin
            state <= state_nx;
            if (squash_valid) begin
                pend      <= 1'b0;
                bar_valid <= 1'b0;
            end else begin
                if (accept) pend <= after_req;
                if (park) begin
                    bar_valid <= 1'b1;
                    bar_tag   <= in_tag;
                    bar_temp  <= in_temp;
                end else if (state == ST_RELEASE) begin
                    bar_valid <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        replay      = (state == ST_RELEASE) && !squash_valid;
        stall       = (state != ST_RUN) || park;
        out_valid   = replay || (accept && !park_req);
        out_tag     = replay ? bar_tag : in_tag;
        out_sb      = replay ? 1'b0 : eff_sb;
        out_handled = replay ? !bar_temp : (in_done || after_req);
        inc_perm    = (park && !in_temp) || (accept && after_req);
        inc_temp    = park && in_temp;
        inc_stall   = (state == ST_HOLD);
    end
endmodule

// File: rtl/serbar_ctrl.sv
module serbar_ctrl
    import serbar_pkg::*;
#(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned OCC_W = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_sb,
    input  logic             in_sa,
    input  logic             in_sc,
    input  logic             in_creg,
    input  logic             in_temp,
    input  logic             in_done,
    input  logic             be_empty,
    input  logic [OCC_W-1:0] fbuf_count,
    input  logic             squash_valid,
    input  logic [TAG_W-1:0] squash_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_sb,
    output logic             out_handled,
    output logic             stall,
    output logic             bar_valid,
    output logic [TAG_W-1:0] bar_tag,
    output logic             replay,
    output logic [CNT_W-1:0] cnt_perm,
    output logic [CNT_W-1:0] cnt_temp,
    output logic [CNT_W-1:0] cnt_stall
);
    bar_state_t           state;
    logic                 pend;
    logic                 eff_sb;
    logic                 park_req;
    logic                 after_req;
    logic                 drained;
    logic [NUM_CNT-1:0]   cnt_inc;
    logic [CNT_W-1:0]     cnt_val [NUM_CNT];

    assign drained = be_empty && (fbuf_count == '0);

    serbar_classify u_cls (
        .in_sb     (in_sb),
        .in_sa     (in_sa),
        .in_sc     (in_sc),
        .in_creg   (in_creg),
        .in_done   (in_done),
        .pend      (pend),
        .eff_sb    (eff_sb),
        .park_req  (park_req),
        .after_req (after_req)
    );

    serbar_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_tag       (in_tag),
        .in_temp      (in_temp),
        .in_done      (in_done),
        .eff_sb       (eff_sb),
        .park_req     (park_req),
        .after_req    (after_req),
        .drained      (drained),
        .squash_valid (squash_valid),
        .state        (state),
        .pend         (pend),
        .out_valid    (out_valid),
        .out_tag      (out_tag),
        .out_sb       (out_sb),
        .out_handled  (out_handled),
        .stall        (stall),
        .bar_valid    (bar_valid),
        .bar_tag      (bar_tag),
        .replay       (replay),
        .inc_perm     (cnt_inc[CNT_PERM]),
        .inc_temp     (cnt_inc[CNT_TEMP]),
        .inc_stall    (cnt_inc[CNT_STALL])
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        serbar_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .value (cnt_val[g])
        );
    end

    assign cnt_perm  = cnt_val[CNT_PERM];
    assign cnt_temp  = cnt_val[CNT_TEMP];
    assign cnt_stall = cnt_val[CNT_STALL];

    logic unused_sq;
    assign unused_sq = ^squash_tag;
endmodule

// File: rtl/serbar_ctrl_chk.sv
module serbar_ctrl_chk
    import serbar_pkg::*;
#(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned OCC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input bar_state_t       state,
    input logic             pend,
    input logic             in_valid,
    input logic [TAG_W-1:0] in_tag,
    input logic             in_sb,
    input logic             in_sa,
    input logic             in_sc,
    input logic             in_creg,
    input logic             in_done,
    input logic             be_empty,
    input logic [OCC_W-1:0] fbuf_count,
    input logic             squash_valid,
    input logic [TAG_W-1:0] squash_tag,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic             out_sb,
    input logic             out_handled,
    input logic             stall,
    input logic             bar_valid,
    input logic [TAG_W-1:0] bar_tag,
    input logic             replay
);
    a_r2_plain_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !squash_valid && !pend &&
         !in_sb && !in_sa && !in_sc && !in_creg)
        |-> (out_valid && out_tag == in_tag && !out_sb));

    a_r3_park_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !squash_valid && !in_done && (in_creg || in_sb))
        |-> (stall && !out_valid));

    a_r3_park_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !squash_valid && !in_done && (in_creg || in_sb))
        |=> (bar_valid && bar_tag == $past(in_tag)));

    a_r4_after_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !squash_valid && !in_done && !pend &&
         !in_creg && !in_sb && (in_sa || in_sc))
        |-> (out_valid && out_handled) ##1 pend);

    a_r6_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && !replay && !(be_empty && fbuf_count == '0))
        |=> !replay);

    a_r7_replay_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        replay |-> (out_valid && out_tag == bar_tag && !out_sb && bar_valid));

    a_r7_bubble_follows: assert property (@(posedge clk) disable iff (!rst_n)
        replay |=> (stall && !out_valid && !bar_valid));

    a_r9_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (!bar_valid && !replay && !pend));

    a_r9_squash_younger: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && bar_valid) |-> (bar_tag > squash_tag));

    a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !replay) |-> !out_valid);
endmodule

bind serbar_ctrl serbar_ctrl_chk #(.TAG_W(TAG_W), .OCC_W(OCC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .pend         (pend),
    .in_valid     (in_valid),
    .in_tag       (in_tag),
    .in_sb        (in_sb),
    .in_sa        (in_sa),
    .in_sc        (in_sc),
    .in_creg      (in_creg),
    .in_done      (in_done),
    .be_empty     (be_empty),
    .fbuf_count   (fbuf_count),
    .squash_valid (squash_valid),
    .squash_tag   (squash_tag),
    .out_valid    (out_valid),
    .out_tag      (out_tag),
    .out_sb       (out_sb),
    .out_handled  (out_handled),
    .stall        (stall),
    .bar_valid    (bar_valid),
    .bar_tag      (bar_tag),
    .replay       (replay)
);

// File: tb/serbar_ctrl_tb.sv
module serbar_ctrl_tb;
    localparam int unsigned TAG_W = 8;
    localparam int unsigned OCC_W = 4;
    localparam int unsigned CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             in_sb = 1'b0, in_sa = 1'b0, in_sc = 1'b0;
    logic             in_creg = 1'b0, in_temp = 1'b0, in_done = 1'b0;
    logic             be_empty = 1'b1;
    logic [OCC_W-1:0] fbuf_count = '0;
    logic             squash_valid = 1'b0;
    logic [TAG_W-1:0] squash_tag = '0;
    logic             out_valid, out_sb, out_handled, stall, bar_valid, replay;
    logic [TAG_W-1:0] out_tag, bar_tag;
    logic [CNT_W-1:0] cnt_perm, cnt_temp, cnt_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serbar_ctrl #(.TAG_W(TAG_W), .OCC_W(OCC_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_sb(in_sb), .in_sa(in_sa), .in_sc(in_sc), .in_creg(in_creg),
        .in_temp(in_temp), .in_done(in_done), .be_empty(be_empty),
        .fbuf_count(fbuf_count), .squash_valid(squash_valid),
        .squash_tag(squash_tag), .out_valid(out_valid), .out_tag(out_tag),
        .out_sb(out_sb), .out_handled(out_handled), .stall(stall),
        .bar_valid(bar_valid), .bar_tag(bar_tag), .replay(replay),
        .cnt_perm(cnt_perm), .cnt_temp(cnt_temp), .cnt_stall(cnt_stall)
    );

    // {tag[7:0], valid, sb, sa, sc, creg, temp, done, exp_valid, exp_handled, exp_sb}
    localparam int NVEC = 8;
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h01, 7'b1000000, 3'b100},
        {8'h02, 7'b1000001, 3'b110},
        {8'h03, 7'b1100001, 3'b111},
        {8'h04, 7'b1000101, 3'b110},
        {8'h05, 7'b1010001, 3'b110},
        {8'h06, 7'b1001001, 3'b110},
        {8'h07, 7'b1000010, 3'b100},
        {8'h08, 7'b0100000, 3'b000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clr_in();
        in_valid = 1'b0; in_sb = 1'b0; in_sa = 1'b0; in_sc = 1'b0;
        in_creg = 1'b0; in_temp = 1'b0; in_done = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk("R1", "stall", stall, 0);
        chk("R1", "bar_valid", bar_valid, 0);
        chk("R1", "replay", replay, 0);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "counters", {cnt_perm, cnt_temp} | cnt_stall, 0);

        // R2 / R5 vector table
        for (int i = 0; i < NVEC; i++) begin
            step();
            {in_tag, in_valid, in_sb, in_sa, in_sc, in_creg, in_temp, in_done} = VEC[i][17:3];
            #5;
            chk("R2", "vec out_valid", out_valid, VEC[i][2]);
            chk("R5", "vec stall", stall, 0);
            if (VEC[i][2]) begin
                chk("R2", "vec out_tag", out_tag, VEC[i][17:10]);
                chk("R5", "vec out_handled", out_handled, VEC[i][1]);
                chk("R5", "vec out_sb", out_sb, VEC[i][0]);
            end
        end
        step(); clr_in(); #5;
        chk("R5", "no count from handled", cnt_perm, 0);

        // R3 permanent park, drain gating
        step(); in_valid = 1; in_creg = 1; in_tag = 8'h10; be_empty = 0; fbuf_count = 2; #5;
        chk("R3", "park out_valid", out_valid, 0);
        chk("R3", "park stall", stall, 1);
        step(); clr_in(); in_valid = 1; in_tag = 8'h11; #5;
        chk("R3", "bar_valid", bar_valid, 1);
        chk("R3", "bar_tag", bar_tag, 8'h10);
        chk("R11", "ignored while held", out_valid, 0);
        chk("R8", "perm count", cnt_perm, 1);
        step(); clr_in(); be_empty = 1; fbuf_count = 1; #5;
        chk("R6", "stall with only be_empty", stall, 1);
        chk("R6", "no replay", replay, 0);
        step(); be_empty = 0; fbuf_count = 0; #5;
        chk("R6", "no replay empty buffer only", replay, 0);
        step(); be_empty = 1; fbuf_count = 0; #5;
        chk("R6", "no replay before edge", replay, 0);
        step(); #5;
        chk("R7", "replay", replay, 1);
        chk("R7", "replay out_valid", out_valid, 1);
        chk("R7", "replay tag", out_tag, 8'h10);
        chk("R7", "replay sb cleared", out_sb, 0);
        chk("R8", "perm replay handled", out_handled, 1);
        chk("R10", "stall cycles", cnt_stall, 4);
        step(); #5;
        chk("R7", "bubble stall", stall, 1);
        chk("R7", "bubble out_valid", out_valid, 0);
        chk("R7", "bubble bar_valid", bar_valid, 0);
        step(); #5;
        chk("R7", "resume", stall, 0);

        // R8 temporary park
        step(); in_valid = 1; in_sb = 1; in_temp = 1; in_tag = 8'h20; #5;
        chk("R3", "temp park out_valid", out_valid, 0);
        step(); clr_in(); #5;
        chk("R8", "temp count", cnt_temp, 1);
        chk("R8", "perm unchanged", cnt_perm, 1);
        step(); #5;
        chk("R7", "temp replay", replay, 1);
        chk("R8", "temp replay not handled", out_handled, 0);
        chk("R7", "temp replay tag", out_tag, 8'h20);
        step(); step(); #5;
        chk("R7", "temp resume", stall, 0);

        // R4 drain-after then forced park, R9 squash
        step(); in_valid = 1; in_sa = 1; in_tag = 8'h30; #5;
        chk("R4", "after passes", out_valid, 1);
        chk("R4", "after handled", out_handled, 1);
        step(); clr_in(); in_valid = 1; in_tag = 8'h31; #5;
        chk("R4", "forced park", out_valid, 0);
        chk("R4", "forced park stall", stall, 1);
        chk("R4", "after count", cnt_perm, 2);
        step(); clr_in(); squash_valid = 1; squash_tag = 8'h30; #5;
        chk("R4", "forced bar_tag", bar_tag, 8'h31);
        chk("R4", "forced park count", cnt_perm, 3);
        step(); squash_valid = 0; #5;
        chk("R9", "squash bar_valid", bar_valid, 0);
        chk("R9", "squash stall", stall, 0);
        step(); in_valid = 1; in_tag = 8'h32; #5;
        chk("R9", "after squash pass", out_valid, 1);

        // R9 squash cancels a pending drain-after obligation
        step(); clr_in(); in_valid = 1; in_sc = 1; in_tag = 8'h40; #5;
        chk("R4", "store-cond handled", out_handled, 1);
        step(); clr_in(); squash_valid = 1; squash_tag = 8'h3f; #5;
        step(); squash_valid = 0; in_valid = 1; in_tag = 8'h41; #5;
        chk("R9", "pending cancelled", out_valid, 1);
        chk("R9", "pending cancelled stall", stall, 0);
        chk("R9", "pending cancelled sb", out_sb, 0);
        step(); clr_in();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule